// File: doc/BRIEF.md
# String Store Byte Sequencer

This block is the part of a load/store unit that carries out an indexed store-string operation. A one-cycle start pulse hands it three 5-bit register fields (source, base and index) and a 7-bit byte count. The sequencer computes the effective address by reading the base and index registers through a single register-file read port. It then checks a translation fault input once. After that it walks consecutive general-purpose registers and writes one byte per memory handshake at increasing addresses until the count is exhausted.

Within each 32-bit register the bytes go out most significant first. After every four bytes the walk moves to the next register, and the register index wraps from 31 to 0. A zero count, or a fault reported while the effective address is being probed, turns the whole operation into a silent no-op. In that case no byte is written and no interrupt is raised. The block keeps no state between operations, so an interrupted operation can be re-issued from the start, and re-issuing it writes the same bytes again.

States, in order: `S_IDLE` waits for start. `S_BASE` reads the base register (or takes zero when the base field is 0). `S_INDEX` adds the index register. `S_PROBE` samples the fault input. `S_LOAD` reads the current source register. `S_SEND` holds one byte on the write port. `S_FINISH` pulses done.

Transitions:
- `S_IDLE` goes to `S_FINISH` on start with a zero count, and to `S_BASE` on start otherwise.
- `S_BASE` goes to `S_INDEX`, and `S_INDEX` goes to `S_PROBE`.
- `S_PROBE` goes to `S_FINISH` on a fault, and to `S_LOAD` otherwise.
- `S_LOAD` goes to `S_SEND`.
- `S_SEND` stays put while ready is low. On an accepted byte it goes to `S_FINISH` if that byte was the last one, to `S_LOAD` if it was the fourth byte of a register, and otherwise stays in `S_SEND`.
- `S_FINISH` goes to `S_IDLE`.

Top module: `string_store_seq`

## Requirements
- R1: The first byte is written at EA = B + GPR[idx], where B is 0 when the base field is 0 and GPR[base] otherwise, and the sum wraps modulo 2^32.
- R2: Byte k of the operation (counting from 0) carries bits [31-8*(k%4) -: 8] of register (src + k/4) mod 32. Bits 31:24 of each register go out first.
- R3: The register index wraps from 31 to 0 when a walk runs past register 31.
- R4: Exactly `count` bytes are accepted, and byte k is written at address EA + k.
- R5: While mem_valid_o is high and mem_ready_i is low, the valid, address and data outputs hold their values on the next cycle.
- R6: A start with count 0 writes nothing. done_o and noop_o then pulse together in the cycle after the start is taken.
- R7: fault_i is sampled only in the probe cycle, which is the third cycle after the start is taken. If it is high there, nothing is written and done_o pulses with noop_o. A fault raised after the first byte has been accepted has no effect on the writes.
- R8: done_o is a one-cycle pulse, and it follows the final accepted byte by one cycle. noop_o is high only together with done_o.
- R9: A start pulse that arrives while an operation is in progress is ignored.
- R10: Issuing the same operation twice with unchanged registers produces the same byte sequence both times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| src_i | input | 5 | First source register |
| base_i | input | 5 | Base register field (0 means base zero) |
| idx_i | input | 5 | Index register |
| count_i | input | 7 | Number of bytes to store |
| rf_idx_o | output | 5 | Register-file read index |
| rf_data_i | input | 32 | Register-file read data (same cycle) |
| fault_i | input | 1 | Translation fault for the probed address |
| mem_valid_o | output | 1 | Byte write request |
| mem_ready_i | input | 1 | Byte write accepted when high with valid |
| mem_addr_o | output | 32 | Byte address (also the probed address) |
| mem_data_o | output | 8 | Byte to write |
| done_o | output | 1 | Operation complete pulse |
| noop_o | output | 1 | Operation completed without writing |

## Verification
Two events can land on the same cycle. The first is the acceptance of the last byte of a register, which must both advance the register index and step the address. The second is that same acceptance being the final byte overall, where the sequencer must finish rather than reload. Counts of 4, 8 and 9, a walk that starts at register 31, and randomly gated ready make these coincide. Every captured address and byte is compared with bench functions, and the cycles after done are checked to be free of writes. A fault raised only after the first accepted byte, and a start held high into a running operation, show that neither event disturbs the sequence in flight.

// File: rtl/ssq_pkg.sv
package ssq_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_BASE,
        S_INDEX,
        S_PROBE,
        S_LOAD,
        S_SEND,
        S_FINISH
    } ssq_state_e;

    typedef enum logic [1:0] {
        RD_BASE,
        RD_INDEX,
        RD_WALK
    } ssq_rdsel_e;
endpackage

// File: rtl/ssq_addr_unit.sv
module ssq_addr_unit #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              ld_base_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              add_idx_i,
    input  logic [ADDR_W-1:0] idx_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] ea_o,
    output logic              last_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [ADDR_W-1:0] ea_q;
    logic [CNT_W-1:0]  cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (cap_i) begin
                cnt_q <= count_i;
            end
            if (ld_base_i) begin
                ea_q <= base_i;
            end else if (add_idx_i) begin
                ea_q <= ea_q + idx_i;
            end else if (step_i) begin
                ea_q <= ea_q + ADDR_W'(1);
            end
            if (step_i) begin
                cnt_q <= cnt_q - ONE;
            end
        end
    end

    assign ea_o   = ea_q;
    assign last_o = (cnt_q == ONE);
endmodule

// File: rtl/ssq_reg_walker.sv
module ssq_reg_walker #(
    parameter int DATA_W = 32,
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic [REG_AW-1:0] src_i,
    input  logic              ld_word_i,
    input  logic [DATA_W-1:0] word_i,
    input  logic              step_i,
    output logic [REG_AW-1:0] reg_o,
    output logic              word_end_o,
    output logic [7:0]        byte_o
);
    localparam int LANES = DATA_W / 8;
    localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1;
    localparam logic [SEL_W-1:0] SEL_LAST = SEL_W'(LANES - 1);

    logic [REG_AW-1:0] reg_q;
    logic [SEL_W-1:0]  sel_q;
    logic [DATA_W-1:0] word_q;
    logic [7:0]        lane [LANES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q  <= '0;
            sel_q  <= '0;
            word_q <= '0;
        end else begin
            if (cap_i) begin
                reg_q <= src_i;
                sel_q <= '0;
            end else if (step_i) begin
                if (sel_q == SEL_LAST) begin
                    sel_q <= '0;
                    reg_q <= reg_q + REG_AW'(1);
                end else begin
                    sel_q <= sel_q + SEL_W'(1);
                end
            end
            if (ld_word_i) begin
                word_q <= word_i;
            end
        end
    end

    // lane 0 is the most significant byte of the register
    generate
        for (genvar b = 0; b < LANES; b++) begin : g_lane
            assign lane[b] = word_q[DATA_W-1-8*b -: 8];
        end
    endgenerate

    assign byte_o     = lane[sel_q];
    assign reg_o      = reg_q;
    assign word_end_o = (sel_q == SEL_LAST);
endmodule

// File: rtl/ssq_ctrl.sv
module ssq_ctrl
    import ssq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       cnt_zero_i,
    input  logic       fault_i,
    input  logic       ready_i,
    input  logic       last_i,
    input  logic       word_end_i,
    output logic       cap_o,
    output logic       ld_base_o,
    output logic       add_idx_o,
    output logic       ld_word_o,
    output logic       step_o,
    output ssq_rdsel_e rdsel_o,
    output logic       valid_o,
    output logic       done_o,
    output logic       noop_o
);
    ssq_state_e state_q, state_d;
    logic       noop_q, noop_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            noop_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            noop_q  <= noop_d;
        end
    end

    always_comb begin
        state_d = state_q;
        noop_d  = noop_q;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) begin
                    noop_d  = cnt_zero_i;
                    state_d = cnt_zero_i ? S_FINISH : S_BASE;
                end
            end
            S_BASE:  state_d = S_INDEX;
            S_INDEX: state_d = S_PROBE;
            S_PROBE: begin
                if (fault_i) begin
                    noop_d  = 1'b1;
                    state_d = S_FINISH;
                end else begin
                    state_d = S_LOAD;
                end
            end
            S_LOAD: state_d = S_SEND;
            S_SEND: begin
                if (ready_i) begin
                    if (last_i) begin
                        state_d = S_FINISH;
                    end else if (word_end_i) begin
                        state_d = S_LOAD;
                    end
                end
            end
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_comb begin
        cap_o     = 1'b0;
        ld_base_o = 1'b0;
        add_idx_o = 1'b0;
        ld_word_o = 1'b0;
        step_o    = 1'b0;
        rdsel_o   = RD_WALK;
        valid_o   = 1'b0;
        done_o    = 1'b0;
        noop_o    = 1'b0;
        unique case (state_q)
            S_IDLE:  cap_o = start_i;
            S_BASE: begin
                rdsel_o   = RD_BASE;
                ld_base_o = 1'b1;
            end
            S_INDEX: begin
                rdsel_o   = RD_INDEX;
                add_idx_o = 1'b1;
            end
            S_PROBE: ;
            S_LOAD:  ld_word_o = 1'b1;
            S_SEND: begin
                valid_o = 1'b1;
                step_o  = ready_i;
            end
            S_FINISH: begin
                done_o = 1'b1;
                noop_o = noop_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/string_store_seq.sv
module string_store_seq
    import ssq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int REG_AW = 5,
    parameter int CNT_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [REG_AW-1:0] src_i,
    input  logic [REG_AW-1:0] base_i,
    input  logic [REG_AW-1:0] idx_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic [REG_AW-1:0] rf_idx_o,
    input  logic [DATA_W-1:0] rf_data_i,
    input  logic              fault_i,
    output logic              mem_valid_o,
    input  logic              mem_ready_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [7:0]        mem_data_o,
    output logic              done_o,
    output logic              noop_o
);
    logic              cap, ld_base, add_idx, ld_word, step;
    logic              last, word_end;
    ssq_rdsel_e        rdsel;
    logic [REG_AW-1:0] base_q, idx_q, walk_reg;
    logic [ADDR_W-1:0] base_val, idx_val;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            idx_q  <= '0;
        end else if (cap) begin
            base_q <= base_i;
            idx_q  <= idx_i;
        end
    end

    always_comb begin
        unique case (rdsel)
            RD_BASE:  rf_idx_o = base_q;
            RD_INDEX: rf_idx_o = idx_q;
            default:  rf_idx_o = walk_reg;
        endcase
    end

    assign base_val = (base_q == '0) ? '0 : ADDR_W'(rf_data_i);
    assign idx_val  = ADDR_W'(rf_data_i);

    ssq_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .cnt_zero_i (count_i == '0),
        .fault_i    (fault_i),
        .ready_i    (mem_ready_i),
        .last_i     (last),
        .word_end_i (word_end),
        .cap_o      (cap),
        .ld_base_o  (ld_base),
        .add_idx_o  (add_idx),
        .ld_word_o  (ld_word),
        .step_o     (step),
        .rdsel_o    (rdsel),
        .valid_o    (mem_valid_o),
        .done_o     (done_o),
        .noop_o     (noop_o)
    );

    ssq_addr_unit #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_i     (cap),
        .count_i   (count_i),
        .ld_base_i (ld_base),
        .base_i    (base_val),
        .add_idx_i (add_idx),
        .idx_i     (idx_val),
        .step_i    (step),
        .ea_o      (mem_addr_o),
        .last_o    (last)
    );

    ssq_reg_walker #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_i      (cap),
        .src_i      (src_i),
        .ld_word_i  (ld_word),
        .word_i     (rf_data_i),
        .step_i     (step),
        .reg_o      (walk_reg),
        .word_end_o (word_end),
        .byte_o     (mem_data_o)
    );
endmodule

// File: rtl/ssq_checker.sv
module ssq_checker #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [CNT_W-1:0]  count_i,
    input logic              mem_valid_o,
    input logic              mem_ready_i,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [7:0]        mem_data_o,
    input logic              done_o,
    input logic              noop_o
);
    logic             busy_q;
    logic [CNT_W-1:0] cnt_lat, wr_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            cnt_lat <= '0;
            wr_cnt  <= '0;
        end else begin
            if (start_i && !busy_q) begin
                busy_q  <= 1'b1;
                cnt_lat <= count_i;
                wr_cnt  <= '0;
            end else begin
                if (done_o) busy_q <= 1'b0;
                if (mem_valid_o && mem_ready_i) wr_cnt <= wr_cnt + CNT_W'(1);
            end
        end
    end

    a_r5_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_addr_o) && $stable(mem_data_o)));

    a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid_o && mem_ready_i) |=> (mem_addr_o == $past(mem_addr_o) + ADDR_W'(1)));

    a_r4_byte_total: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !noop_o) |-> (wr_cnt == cnt_lat));

    a_r6_r7_noop_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && noop_o) |-> (wr_cnt == '0));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r8_noop_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        noop_o |-> done_o);

    a_r9_write_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid_o |-> busy_q);
endmodule

bind string_store_seq ssq_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ssq_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .count_i     (count_i),
    .mem_valid_o (mem_valid_o),
    .mem_ready_i (mem_ready_i),
    .mem_addr_o  (mem_addr_o),
    .mem_data_o  (mem_data_o),
    .done_o      (done_o),
    .noop_o      (noop_o)
);

// File: tb/string_store_seq_test.sv
module string_store_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  src = '0, base = '0, idx = '0;
    logic [6:0]  count = '0;
    logic [4:0]  rf_idx;
    logic [31:0] rf_data;
    logic        fault;
    logic        mem_valid, mem_ready = 1'b1;
    logic [31:0] mem_addr;
    logic [7:0]  mem_data;
    logic        done, noop;

    logic [31:0] regs [32];
    logic [31:0] got_addr [4096];
    logic [7:0]  got_data [4096];
    int          wtotal = 0;
    int          op_base = 0;
    logic        fault_early = 1'b0, fault_late = 1'b0;
    int          errors = 0, checks = 0;

    always #10 clk = ~clk;

    assign rf_data = regs[rf_idx];
    assign fault   = fault_early | (fault_late && (wtotal != op_base));

    string_store_seq uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .src_i(src), .base_i(base),
        .idx_i(idx), .count_i(count), .rf_idx_o(rf_idx), .rf_data_i(rf_data),
        .fault_i(fault), .mem_valid_o(mem_valid), .mem_ready_i(mem_ready),
        .mem_addr_o(mem_addr), .mem_data_o(mem_data), .done_o(done), .noop_o(noop)
    );

    always @(posedge clk) begin
        if (mem_valid && mem_ready) begin
            got_addr[wtotal % 4096] <= mem_addr;
            got_data[wtotal % 4096] <= mem_data;
            wtotal <= wtotal + 1;
        end
    end

    function automatic logic [31:0] exp_ea(input logic [4:0] b, input logic [4:0] x);
        return ((b == 5'd0) ? 32'd0 : regs[b]) + regs[x];
    endfunction

    function automatic logic [7:0] exp_byte(input logic [4:0] s, input int k);
        logic [4:0]  r = s + 5'(k / 4);
        logic [31:0] w = regs[r];
        return w[31 - 8 * (k % 4) -: 8];
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [4:0] s, input logic [4:0] b, input logic [4:0] x,
                          input logic [6:0] n, input bit f_early, input bit f_late,
                          input bit hold_start, input string tag);
        int  waited = 0;
        int  expn;
        bit  got_noop;
        int  after;
        @(negedge clk);
        op_base     = wtotal;
        fault_early = f_early;
        fault_late  = f_late;
        src = s; base = b; idx = x; count = n;
        start = 1'b1;
        @(negedge clk);
        if (hold_start) begin
            src = s + 5'd3; count = 7'd5;
            @(negedge clk);
            @(negedge clk);
        end
        start = 1'b0;
        while (!done && waited < 3000) begin
            @(negedge clk);
            waited++;
        end
        check(waited < 3000, {tag, " watchdog"}, 64'(waited), 64'd0);
        got_noop = noop;
        expn = (n == 0 || f_early) ? 0 : int'(n);
        check(got_noop == (expn == 0), {tag, " R6 R7 noop flag"}, 64'(got_noop), 64'(expn == 0));
        check(wtotal - op_base == expn, {tag, " R4 byte count"}, 64'(wtotal - op_base), 64'(expn));
        for (int k = 0; k < expn && k < wtotal - op_base; k++) begin
            logic [31:0] ea = exp_ea(b, x) + 32'(k);
            logic [7:0]  eb = exp_byte(s, k);
            int          p  = (op_base + k) % 4096;
            check(got_addr[p] == ea && got_data[p] == eb, {tag, " R1 R2 R3 byte"},
                  {got_addr[p], 24'd0, got_data[p]}, {ea, 24'd0, eb});
        end
        @(negedge clk);
        check(!done, {tag, " R8 single done"}, 64'(done), 64'd0);
        after = wtotal;
        repeat (3) @(negedge clk);
        check(wtotal == after && !mem_valid, {tag, " R9 quiet after done"}, 64'(wtotal - after), 64'd0);
        fault_early = 1'b0;
        fault_late  = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd1234));
        forever begin
            @(negedge clk);
            mem_ready = ($urandom % 4) != 0;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) regs[i] = $urandom;
        repeat (3) @(negedge clk);
        check(!mem_valid && !done && !noop, "reset outputs idle", {61'd0, mem_valid, done, noop}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        run_op(5'd4, 5'd2, 5'd3, 7'd0, 1'b0, 1'b0, 1'b0, "R6 zero count");
        run_op(5'd4, 5'd2, 5'd3, 7'd6, 1'b1, 1'b0, 1'b0, "R7 early fault");
        run_op(5'd7, 5'd0, 5'd9, 7'd5, 1'b0, 1'b0, 1'b0, "R1 base field zero");
        run_op(5'd31, 5'd1, 5'd2, 7'd9, 1'b0, 1'b0, 1'b0, "R3 wrap from 31");
        run_op(5'd30, 5'd5, 5'd6, 7'd127, 1'b0, 1'b0, 1'b0, "R3 R4 max count");
        run_op(5'd10, 5'd11, 5'd12, 7'd8, 1'b0, 1'b1, 1'b0, "R7 late fault ignored");
        run_op(5'd3, 5'd8, 5'd8, 7'd1, 1'b0, 1'b0, 1'b0, "R8 single byte");
        run_op(5'd12, 5'd13, 5'd14, 7'd4, 1'b0, 1'b0, 1'b1, "R9 start while busy");
        run_op(5'd20, 5'd21, 5'd22, 7'd11, 1'b0, 1'b0, 1'b0, "R10 first issue");
        run_op(5'd20, 5'd21, 5'd22, 7'd11, 1'b0, 1'b0, 1'b0, "R10 reissue");
        for (int t = 0; t < 20; t++) begin
            run_op(5'($urandom), 5'($urandom), 5'($urandom), 7'($urandom),
                   ($urandom % 8) == 0, 1'b0, 1'b0, "R2 R4 random");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule